// File: doc/BRIEF.md
# Reset Cause Recorder and Protected System Control

This block sits beside the clock and reset tree of a small processor core. It keeps track of why the chip last restarted and keeps a flag that tells a cold power-up apart from a restart that software asked for. It raises a reset pulse for the rest of the chip when one of three things happens: the external reset pin, a watchdog overflow while the watchdog is armed to reset, or a software request. Only the asynchronous power-on input resets the block itself. For that reason the recorded cause and the boot flag survive the restart they describe.

The block also holds three more pieces of state. The first is the watchdog mode bit, which chooses between a plain overflow flag and a reset on overflow. The second is the overflow flag itself, which is cleared by a count reload or by the interrupt acknowledge. The third is a power-down request bit that the wake-up logic clears. The watchdog mode bit and the software reset request are protected. They can be written only inside a short window that a two-byte key sequence opens.

Software reaches the block through a byte-wide register bus. Writes take effect on a clock edge. Read data is combinational and depends on the address alone.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The cause code reads on status (address 1) bits [1:0]. It is 00 for software, 01 for power-on, 10 for watchdog and 11 for the reset pin. A clock edge that samples `pin_rst_i` high records 11 and asserts `sys_rst_o`.
- R2: After `por_n` is released, the cause reads 01, the boot flag (status bit 2) reads 1, and the config, power and flag bits read 0. The boot flag never goes from 0 to 1 except through power-on.
- R3: Writing 1 to config (address 0) bit 1 inside the unlock window issues a software reset on the following edge. That reset records cause 00 and clears the boot flag. The request bit reads 0 again once it has been serviced.
- R4: A software request is dropped without effect while the boot flag is 1 and the watchdog mode bit (config bit 0) is 0.
- R5: With config bit 0 at 1, a watchdog overflow records cause 10 and asserts `sys_rst_o`.
- R6: With config bit 0 at 0, an overflow sets the flag (status bit 3, `wdt_flag_o`) and causes no reset. A reload or an interrupt acknowledge clears the flag. A new overflow in the same cycle as a clear wins over the clear.
- R7: The power-down bit (address 2, bit 0, `pwr_down_o`) follows software writes. `wake_i` clears it, and wake wins over a write in the same cycle.
- R8: Writes to config outside the unlock window leave it unchanged.
- R9: Writing 0x5A and then 0xA5 to address 3 opens the window, with no other bus write between the two. The window is shown on status bit 4 and `safe_open_o`. Config writes are accepted on the 16 clock edges that follow the second key and refused after that.
- R10: A recorded pin, watchdog or software reset leaves the cause and boot flag as recorded. It returns the watchdog mode bit, the flag, the power-down bit and the unlock window to 0.
- R11: When reset sources coincide, the recorded cause follows this priority: pin first, then watchdog, then software.
- R12: `sys_rst_o` stays high for 4 cycles after the last edge that recorded a reset. A pin held high keeps extending the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pin_rst_i | input | 1 | External reset request, synchronous level |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wdt_reload_i | input | 1 | Watchdog count reload, clears the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge for the watchdog flag |
| wake_i | input | 1 | Wake-up event, clears power-down |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| sys_rst_o | output | 1 | Reset pulse to the rest of the chip |
| wdt_flag_o | output | 1 | Watchdog overflow flag |
| pwr_down_o | output | 1 | Power-down request |
| safe_open_o | output | 1 | Protected-write window open |

## Verification
The bound checker watches a set of single-step relationships on every cycle. These are: the cause code after a pin or watchdog event, software requests that are blocked while the boot flag is set, the one-cycle life of a serviced request, a boot flag that never rises, wake clearing power-down, config stability while locked, and the return to defaults after each event. Some behaviours span many cycles and can only be shown by the bench's scenarios. These include the exact edge on which the 16-cycle window closes, a key sequence broken by another write, the four-cycle pulse and its extension by a held pin, the chain of clears on the overflow flag, and the return of the boot flag after a fresh power-on.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    CAUSE_SW   = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_WDOG = 2'b10,
    CAUSE_PIN  = 2'b11
  } cause_e;

  localparam logic [ADDR_W-1:0] ADR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_PWR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_KEY  = 2'd3;

endpackage

// File: rtl/rcc_unlock.sv
module rcc_unlock
  import rcc_pkg::*;
#(
  parameter int              SAFE_CYC = 16,
  parameter logic [BUS_W-1:0] KEY_A   = 8'h5A,
  parameter logic [BUS_W-1:0] KEY_B   = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              close_i,
  output logic              open_o
);

  localparam int CNT_W = $clog2(SAFE_CYC + 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] win_q, win_d;
  logic             key_wr;

  assign key_wr = wr_i && (addr_i == ADR_KEY);

  always_comb begin
    armed_d = armed_q;
    win_d   = win_q;
    if (win_q != '0) begin
      win_d = win_q - 1'b1;
    end
    if (wr_i) begin
      // any write breaks a pending sequence unless it completes or restarts it
      armed_d = 1'b0;
      if (key_wr && armed_q && (wdata_i == KEY_B)) begin
        win_d = CNT_W'(SAFE_CYC);
      end else if (key_wr && (wdata_i == KEY_A)) begin
        armed_d = 1'b1;
      end
    end
    if (close_i) begin
      armed_d = 1'b0;
      win_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      armed_q <= armed_d;
      win_q   <= win_d;
    end
  end

  assign open_o = (win_q != '0);

endmodule

// File: rtl/rcc_arbiter.sv
module rcc_arbiter
  import rcc_pkg::*;
#(
  parameter int RST_PULSE = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_i,
  input  logic   wdt_ovf_i,
  input  logic   wdog_en_i,
  input  logic   sw_req_i,
  output cause_e cause_o,
  output logic   boot_o,
  output logic   evt_o,
  output logic   sys_rst_o
);

  localparam int PW = $clog2(RST_PULSE + 1);

  cause_e        cause_q, cause_d;
  logic          boot_q, boot_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          wd_hit, sw_ok, evt;

  assign wd_hit = wdt_ovf_i && wdog_en_i;
  assign sw_ok  = sw_req_i && (!boot_q || wdog_en_i);
  assign evt    = pin_i || wd_hit || sw_ok;

  always_comb begin
    cause_d = cause_q;
    boot_d  = boot_q;
    if (pin_i) begin
      cause_d = CAUSE_PIN;
    end else if (wd_hit) begin
      cause_d = CAUSE_WDOG;
    end else if (sw_ok) begin
      cause_d = CAUSE_SW;
      boot_d  = 1'b0;
    end
  end

  always_comb begin
    pulse_d = pulse_q;
    if (evt) begin
      pulse_d = PW'(RST_PULSE);
    end else if (pulse_q != '0) begin
      pulse_d = pulse_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_POR;
      boot_q  <= 1'b1;
      pulse_q <= '0;
    end else begin
      cause_q <= cause_d;
      boot_q  <= boot_d;
      pulse_q <= pulse_d;
    end
  end

  assign cause_o   = cause_q;
  assign boot_o    = boot_q;
  assign evt_o     = evt;
  assign sys_rst_o = (pulse_q != '0);

endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        wdata_i,
  input  logic              safe_open_i,
  input  logic              evt_i,
  input  logic              wdt_ovf_i,
  input  logic              wdt_reload_i,
  input  logic              irq_ack_i,
  input  logic              wake_i,
  output logic              wdog_en_o,
  output logic              sw_req_o,
  output logic              wdt_flag_o,
  output logic              pd_o
);

  logic wdog_en_q, wdog_en_d;
  logic sw_q, sw_d;
  logic flag_q, flag_d;
  logic pd_q, pd_d;
  logic cfg_en, pwr_en;

  assign cfg_en = wr_i && (addr_i == ADR_CFG) && safe_open_i;
  assign pwr_en = wr_i && (addr_i == ADR_PWR);

  always_comb begin
    wdog_en_d = cfg_en ? wdata_i[0] : wdog_en_q;
    sw_d      = cfg_en && wdata_i[1];

    flag_d = flag_q;
    if (wdt_reload_i || irq_ack_i) flag_d = 1'b0;
    if (wdt_ovf_i && !wdog_en_q)   flag_d = 1'b1;

    pd_d = pwr_en ? wdata_i[0] : pd_q;
    if (wake_i) pd_d = 1'b0;

    if (evt_i) begin
      wdog_en_d = 1'b0;
      sw_d      = 1'b0;
      flag_d    = 1'b0;
      pd_d      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdog_en_q <= 1'b0;
      sw_q      <= 1'b0;
      flag_q    <= 1'b0;
      pd_q      <= 1'b0;
    end else begin
      wdog_en_q <= wdog_en_d;
      sw_q      <= sw_d;
      flag_q    <= flag_d;
      pd_q      <= pd_d;
    end
  end

  assign wdog_en_o  = wdog_en_q;
  assign sw_req_o   = sw_q;
  assign wdt_flag_o = flag_q;
  assign pd_o       = pd_q;

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int               SAFE_CYC  = 16,
  parameter int               RST_PULSE = 4,
  parameter logic [BUS_W-1:0] KEY_A     = 8'h5A,
  parameter logic [BUS_W-1:0] KEY_B     = 8'hA5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_rst_i,
  input  logic              wdt_ovf_i,
  input  logic              wdt_reload_i,
  input  logic              irq_ack_i,
  input  logic              wake_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              sys_rst_o,
  output logic              wdt_flag_o,
  output logic              pwr_down_o,
  output logic              safe_open_o
);

  logic [1:0] sync_q;
  logic       rst_n;
  logic       safe_open, rst_evt, wdog_en, sw_req, boot, wdt_flag, pd;
  cause_e     cause;

  // asynchronous assertion, release after two edges
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n = sync_q[1];

  rcc_unlock #(
    .SAFE_CYC (SAFE_CYC),
    .KEY_A    (KEY_A),
    .KEY_B    (KEY_B)
  ) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .close_i (rst_evt),
    .open_o  (safe_open)
  );

  rcc_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (bus_wr_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i[1:0]),
    .safe_open_i  (safe_open),
    .evt_i        (rst_evt),
    .wdt_ovf_i    (wdt_ovf_i),
    .wdt_reload_i (wdt_reload_i),
    .irq_ack_i    (irq_ack_i),
    .wake_i       (wake_i),
    .wdog_en_o    (wdog_en),
    .sw_req_o     (sw_req),
    .wdt_flag_o   (wdt_flag),
    .pd_o         (pd)
  );

  rcc_arbiter #(
    .RST_PULSE (RST_PULSE)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_rst_i),
    .wdt_ovf_i (wdt_ovf_i),
    .wdog_en_i (wdog_en),
    .sw_req_i  (sw_req),
    .cause_o   (cause),
    .boot_o    (boot),
    .evt_o     (rst_evt),
    .sys_rst_o (sys_rst_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADR_CFG:  bus_rdata_o[1:0] = {sw_req, wdog_en};
      ADR_STAT: bus_rdata_o[4:0] = {safe_open, wdt_flag, boot, cause};
      ADR_PWR:  bus_rdata_o[0]   = pd;
      default:  bus_rdata_o      = '0;
    endcase
  end

  assign wdt_flag_o  = wdt_flag;
  assign pwr_down_o  = pd;
  assign safe_open_o = safe_open;

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin,
  input logic       wdt_ovf,
  input logic       wake,
  input logic       bus_wr,
  input logic       wdog_en,
  input logic       sw_req,
  input logic       boot,
  input logic [1:0] cause,
  input logic       rst_evt,
  input logic       sys_rst,
  input logic       wdt_flag,
  input logic       pd,
  input logic       safe_open
);

  p_pin_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pin |=> (cause == 2'b11) && sys_rst);

  p_boot_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(boot));

  p_sw_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !boot && !pin && !(wdt_ovf && wdog_en)) |=>
      (cause == 2'b00) && sys_rst && !boot);

  p_sw_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !bus_wr) |=> !sw_req);

  p_sw_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && boot && !wdog_en && !pin && !sys_rst) |=> !sys_rst);

  p_wdog_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf && wdog_en && !pin) |=> (cause == 2'b10) && sys_rst);

  p_wdog_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf && !wdog_en && !rst_evt) |=> wdt_flag && !sys_rst);

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !pd);

  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!safe_open && !rst_evt) |=> $stable(wdog_en));

  p_evt_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> !wdog_en && !pd && !safe_open && !wdt_flag);

  p_wdog_over_sw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf && wdog_en && sw_req && !pin) |=> (cause == 2'b10));

  p_pulse_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> sys_rst);

endmodule

bind rst_cause_ctrl rcc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin       (pin_rst_i),
  .wdt_ovf   (wdt_ovf_i),
  .wake      (wake_i),
  .bus_wr    (bus_wr_i),
  .wdog_en   (wdog_en),
  .sw_req    (sw_req),
  .boot      (boot),
  .cause     (cause),
  .rst_evt   (rst_evt),
  .sys_rst   (sys_rst_o),
  .wdt_flag  (wdt_flag),
  .pd        (pd),
  .safe_open (safe_open)
);

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n, pin_rst, wdt_ovf, wdt_reload, irq_ack, wake, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       sys_rst, wdt_flag, pwr_down, safe_open;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_ctrl u_dut (
    .clk          (clk),
    .por_n        (por_n),
    .pin_rst_i    (pin_rst),
    .wdt_ovf_i    (wdt_ovf),
    .wdt_reload_i (wdt_reload),
    .irq_ack_i    (irq_ack),
    .wake_i       (wake),
    .bus_wr_i     (bus_wr),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .sys_rst_o    (sys_rst),
    .wdt_flag_o   (wdt_flag),
    .pwr_down_o   (pwr_down),
    .safe_open_o  (safe_open)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic unlock();
    wr(2'd3, 8'h5A);
    wr(2'd3, 8'hA5);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (sys_rst && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_por();
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R2 cfg after por", d, 8'h00);
    rd(2'd1, d); check("R2 status after por", d, 8'h05);
    rd(2'd2, d); check("R2 pwr after por", d, 8'h00);
    check("R2 sys_rst after por", sys_rst, 0);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R8 cfg write while locked", d, 8'h00);
    wr(2'd3, 8'h5A);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hA5);
    check("R9 broken key sequence", safe_open, 0);
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R8 cfg after broken sequence", d, 8'h00);
  endtask

  task automatic t_window();
    logic [7:0] d;
    unlock();
    rd(2'd1, d); check("R9 window flag set", d[4], 1);
    idle(15);
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R9 write on 16th edge", d, 8'h01);
    rd(2'd1, d); check("R9 window closed", d[4], 0);
    unlock();
    idle(16);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R9 write on 17th edge refused", d, 8'h01);
  endtask

  task automatic t_sw_blocked();
    logic [7:0] d;
    unlock();
    wr(2'd0, 8'h02);
    idle(1);
    check("R4 no reset while boot set", sys_rst, 0);
    rd(2'd1, d); check("R4 cause unchanged", d[1:0], 2'b01);
    rd(2'd0, d); check("R3 request self-clears", d, 8'h00);
    idle(20);
  endtask

  task automatic t_wdog_flag();
    logic [7:0] d;
    wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
    check("R6 flag set", wdt_flag, 1);
    check("R6 no reset", sys_rst, 0);
    rd(2'd1, d); check("R6 status flag bit", d[3], 1);
    wdt_reload = 1'b1; @(negedge clk); wdt_reload = 1'b0;
    check("R6 reload clears", wdt_flag, 0);
    wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R6 ack clears", wdt_flag, 0);
    wdt_ovf = 1'b1; wdt_reload = 1'b1; @(negedge clk);
    wdt_ovf = 1'b0; wdt_reload = 1'b0;
    check("R6 set wins over clear", wdt_flag, 1);
    wdt_reload = 1'b1; @(negedge clk); wdt_reload = 1'b0;
  endtask

  task automatic t_pd();
    logic [7:0] d;
    wr(2'd2, 8'h01);
    rd(2'd2, d); check("R7 pd written", d, 8'h01);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    check("R7 wake clears", pwr_down, 0);
    wake = 1'b1; wr(2'd2, 8'h01); wake = 1'b0;
    check("R7 wake wins over write", pwr_down, 0);
  endtask

  task automatic t_sw_reset_armed();
    logic [7:0] d;
    int n;
    wr(2'd2, 8'h01);
    unlock();
    wr(2'd0, 8'h03);
    check("R3 pulse not yet", sys_rst, 0);
    idle(1);
    check("R3 reset issued", sys_rst, 1);
    rd(2'd1, d); check("R3 cause sw, boot cleared", d, 8'h00);
    rd(2'd0, d); check("R10 cfg defaults", d, 8'h00);
    check("R10 pd default", pwr_down, 0);
    pulse_len(n); check("R12 pulse length", n, 4);
    rd(2'd1, d); check("R10 cause kept", d[2:0], 3'b000);
  endtask

  task automatic t_pin();
    logic [7:0] d;
    int n;
    pin_rst = 1'b1; idle(3); pin_rst = 1'b0;
    check("R1 pin asserts reset", sys_rst, 1);
    rd(2'd1, d); check("R1 cause pin", d[1:0], 2'b11);
    check("R1 boot untouched by pin", d[2], 0);
    pulse_len(n); check("R12 pulse after held pin", n, 4);
  endtask

  task automatic t_sw_boot_clear();
    logic [7:0] d;
    int n;
    unlock();
    wr(2'd0, 8'h02);
    idle(1);
    check("R3 sw reset with boot clear", sys_rst, 1);
    rd(2'd1, d); check("R3 cause sw after pin", d[1:0], 2'b00);
    pulse_len(n);
  endtask

  task automatic t_wdog_reset();
    logic [7:0] d;
    int n;
    unlock();
    wr(2'd0, 8'h01);
    wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
    check("R5 overflow resets", sys_rst, 1);
    rd(2'd1, d); check("R5 cause watchdog", d[1:0], 2'b10);
    check("R10 flag cleared", d[3], 0);
    check("R10 window closed", d[4], 0);
    pulse_len(n);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    int n;
    unlock();
    wr(2'd0, 8'h01);
    pin_rst = 1'b1; wdt_ovf = 1'b1; @(negedge clk);
    pin_rst = 1'b0; wdt_ovf = 1'b0;
    rd(2'd1, d); check("R11 pin beats watchdog", d[1:0], 2'b11);
    pulse_len(n);
    unlock();
    wr(2'd0, 8'h03);
    wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
    rd(2'd1, d); check("R11 watchdog beats sw", d[1:0], 2'b10);
    pulse_len(n);
  endtask

  task automatic t_repor();
    logic [7:0] d;
    do_por();
    rd(2'd1, d); check("R2 power-on sets boot again", d, 8'h05);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    por_n = 1'b0; pin_rst = 1'b0; wdt_ovf = 1'b0; wdt_reload = 1'b0;
    irq_ack = 1'b0; wake = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
    bus_wdata = 8'h00;
    idle(2);
    por_n = 1'b1;
    idle(3);
    t_reset();
    t_locked();
    t_window();
    t_sw_blocked();
    t_wdog_flag();
    t_pd();
    t_sw_reset_armed();
    t_pin();
    t_sw_boot_clear();
    t_wdog_reset();
    t_prio();
    t_repor();
    done = 1'b1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule